// File: doc/BRIEF.md
# Peak-Tracking Decision Threshold Estimator

This block takes signed digital samples of a filtered baseband receive signal, where zero is the bias level. It keeps two level registers, one for the upper envelope and one for the lower envelope. The midpoint of the two registers is the decision threshold, and each strobed sample is sliced against that threshold into a data bit. One sample strobe stands for one bit time. Every register update happens only on a strobe.

Two controls choose the update rule. The first is an acquire input. The second is an active-low freeze input. When acquire rises, the block spends one strobe pulling both registers toward half of the incoming sample. While acquire stays high, the registers capture peaks quickly. When acquire is low, the registers average slowly toward the peaks. When the freeze input is also low, the registers only leak slowly toward zero. Every rule is a first-order step whose rate is set by a shift.

Top module: `peak_slicer`

## Requirements
- R1: On the first strobe with acquire high after a strobe with acquire low (and on the first strobe after reset with acquire high), the mode output reads 0 (clamp). On that strobe both registers become reg + ((smp>>>1) - reg)>>>1. Clamp lasts for that single strobe only.
- R2: On later strobes with acquire high, the mode reads 1 (fast). The upper register becomes up + (smp-up)>>>1 only when smp > up. The lower register becomes lo + (smp-lo)>>>1 only when smp < lo. Otherwise each register keeps its value.
- R3: With acquire low and freeze_n high, the mode reads 2 (average). The upper register moves by (smp-up)>>>4 only when smp is above the threshold. The lower register moves by (smp-lo)>>>4 only when smp is below the threshold.
- R4: With acquire low and freeze_n low, the mode reads 3 (hold). On each strobe each register becomes reg - (reg>>>11), which moves it toward zero.
- R5: While acquire is high, freeze_n has no effect on the mode or on the register updates.
- R6: The threshold output always equals floor((up + lo) / 2).
- R7: On each strobe, the data output is registered as 0 when smp is greater than the threshold in force before that strobe, and as 1 otherwise (including when they are equal).
- R8: Reset clears both registers and the data output to 0. Without a strobe, the registers and the data output keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe, once per bit time |
| smp_in | input | SAMPLE_W | Signed sample, zero is the bias level |
| lvl_acq | input | 1 | Level acquire control |
| freeze_n | input | 1 | Active-low hold control |
| pk_up | output | SAMPLE_W | Upper level register |
| pk_lo | output | SAMPLE_W | Lower level register |
| thresh | output | SAMPLE_W | Decision threshold |
| mode | output | 2 | Mode in force for the next strobe: 0 clamp, 1 fast, 2 average, 3 hold |
| bit_out | output | 1 | Sliced data bit |

## Verification
The assertions assume that the strobe is a single-cycle pulse and that the sample stays steady during the strobe cycle. The monotonic-leak and ordered-threshold properties also assume that the upper register stays at or above the lower one, which holds when acquisition starts from a clamp and the samples are not the most negative code. The bench changes every input only on the falling edge of the clock. It keeps samples within about ±16000, far from the code limits. It enters fast capture only through a clamp, so the registers stay ordered.

// File: rtl/peak_slicer_pkg.sv
package peak_slicer_pkg;

    typedef enum logic [1:0] {
        M_CLAMP = 2'd0,
        M_FAST  = 2'd1,
        M_AVG   = 2'd2,
        M_HOLD  = 2'd3
    } lvl_mode_e;

    // first-order step of cur toward tgt, rate set by a right shift
    function automatic int step_toward(input int cur, input int tgt, input int sh);
        return cur + ((tgt - cur) >>> sh);
    endfunction

    // slow decay of cur toward zero
    function automatic int leak_zero(input int cur, input int sh);
        return cur - (cur >>> sh);
    endfunction

endpackage

// File: rtl/lvl_mode_ctrl.sv
module lvl_mode_ctrl
    import peak_slicer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stb,
    input  logic      acq,
    input  logic      freeze_n,
    output lvl_mode_e mode
);
    logic acq_seen;

    always_ff @(posedge clk) begin
        if (rst)      acq_seen <= 1'b0;
        else if (stb) acq_seen <= acq;
    end

    always_comb begin
        if (acq)           mode = acq_seen ? M_FAST : M_CLAMP;
        else if (freeze_n) mode = M_AVG;
        else               mode = M_HOLD;
    end
endmodule

// File: rtl/lvl_tracker.sv
module lvl_tracker
    import peak_slicer_pkg::*;
#(
    parameter int W       = 16,
    parameter bit IS_UP   = 1'b1,
    parameter int CLAMP_SH = 1,
    parameter int FAST_SH = 1,
    parameter int AVG_SH  = 4,
    parameter int LEAK_SH = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  lvl_mode_e           mode,
    input  logic signed [W-1:0] smp,
    input  logic signed [W-1:0] thr,
    output logic signed [W-1:0] lvl
);
    logic signed [W-1:0] nxt;
    logic                past_peak;
    logic                past_thr;
    int                  cur_i;
    int                  smp_i;

    assign cur_i     = int'(lvl);
    assign smp_i     = int'(smp);
    assign past_peak = IS_UP ? (smp > lvl) : (smp < lvl);
    assign past_thr  = IS_UP ? (smp > thr) : (smp < thr);

    always_comb begin
        unique case (mode)
            M_CLAMP: nxt = W'(step_toward(cur_i, smp_i >>> 1, CLAMP_SH));
            M_FAST:  nxt = past_peak ? W'(step_toward(cur_i, smp_i, FAST_SH)) : lvl;
            M_AVG:   nxt = past_thr  ? W'(step_toward(cur_i, smp_i, AVG_SH))  : lvl;
            default: nxt = W'(leak_zero(cur_i, LEAK_SH));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      lvl <= '0;
        else if (stb) lvl <= nxt;
    end
endmodule

// File: rtl/lvl_slicer.sv
module lvl_slicer #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic signed [W-1:0] up,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] smp,
    output logic signed [W-1:0] thr,
    output logic                bit_q
);
    logic signed [W:0] sum;

    assign sum = {up[W-1], up} + {lo[W-1], lo};
    assign thr = sum[W:1];

    always_ff @(posedge clk) begin
        if (rst)      bit_q <= 1'b0;
        else if (stb) bit_q <= (smp > thr) ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/peak_slicer.sv
module peak_slicer
    import peak_slicer_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CLAMP_SH = 1,
    parameter int FAST_SH  = 1,
    parameter int AVG_SH   = 4,
    parameter int LEAK_SH  = 11
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_stb,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    input  logic                       lvl_acq,
    input  logic                       freeze_n,
    output logic signed [SAMPLE_W-1:0] pk_up,
    output logic signed [SAMPLE_W-1:0] pk_lo,
    output logic signed [SAMPLE_W-1:0] thresh,
    output logic [1:0]                 mode,
    output logic                       bit_out
);
    localparam int NSIDE = 2;

    lvl_mode_e           cur_mode;
    logic signed [SAMPLE_W-1:0] lvl [NSIDE];

    lvl_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .acq      (lvl_acq),
        .freeze_n (freeze_n),
        .mode     (cur_mode)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        lvl_tracker #(
            .W        (SAMPLE_W),
            .IS_UP    (g == 0),
            .CLAMP_SH (CLAMP_SH),
            .FAST_SH  (FAST_SH),
            .AVG_SH   (AVG_SH),
            .LEAK_SH  (LEAK_SH)
        ) u_trk (
            .clk  (clk),
            .rst  (rst),
            .stb  (smp_stb),
            .mode (cur_mode),
            .smp  (smp_in),
            .thr  (thresh),
            .lvl  (lvl[g])
        );
    end

    lvl_slicer #(.W(SAMPLE_W)) u_slice (
        .clk   (clk),
        .rst   (rst),
        .stb   (smp_stb),
        .up    (lvl[0]),
        .lo    (lvl[1]),
        .smp   (smp_in),
        .thr   (thresh),
        .bit_q (bit_out)
    );

    assign pk_up = lvl[0];
    assign pk_lo = lvl[1];
    assign mode  = cur_mode;
endmodule

// File: rtl/peak_slicer_chk.sv
module peak_slicer_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_stb,
    input logic signed [W-1:0] smp_in,
    input logic                lvl_acq,
    input logic                freeze_n,
    input logic signed [W-1:0] pk_up,
    input logic signed [W-1:0] pk_lo,
    input logic signed [W-1:0] thresh,
    input logic [1:0]          mode,
    input logic                bit_out
);
    AST_CLAMP_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mode == 2'd0) |=> (mode != 2'd0)); // R1

    AST_FAST_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mode == 2'd1) |=> (pk_up >= $past(pk_up) && pk_lo <= $past(pk_lo))); // R2

    AST_AVG_SIDE_GATE: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mode == 2'd2 && !(smp_in > thresh)) |=> $stable(pk_up)); // R3

    AST_HOLD_LEAK_UP: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mode == 2'd3 && pk_up >= 0) |=> (pk_up <= $past(pk_up) && pk_up >= 0)); // R4

    AST_HOLD_LEAK_LO: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mode == 2'd3 && pk_lo <= 0) |=> (pk_lo >= $past(pk_lo) && pk_lo <= 0)); // R4

    AST_FREEZE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        lvl_acq |-> (mode == 2'd0 || mode == 2'd1)); // R5

    AST_THR_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (pk_lo <= pk_up) |-> (thresh >= pk_lo && thresh <= pk_up)); // R6

    AST_SLICE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && smp_in > thresh) |=> (bit_out == 1'b0)); // R7

    AST_SLICE_LOW: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && smp_in < thresh) |=> (bit_out == 1'b1)); // R7

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(pk_up) && $stable(pk_lo) && $stable(bit_out))); // R8
endmodule

bind peak_slicer peak_slicer_chk #(.W(SAMPLE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .smp_in   (smp_in),
    .lvl_acq  (lvl_acq),
    .freeze_n (freeze_n),
    .pk_up    (pk_up),
    .pk_lo    (pk_lo),
    .thresh   (thresh),
    .mode     (mode),
    .bit_out  (bit_out)
);

// File: tb/tb_peak_slicer.sv
module tb_peak_slicer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                smp_stb = 1'b0;
    logic signed [W-1:0] smp_in = '0;
    logic                lvl_acq = 1'b0;
    logic                freeze_n = 1'b1;
    logic signed [W-1:0] pk_up, pk_lo, thresh;
    logic [1:0]          mode;
    logic                bit_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    up;
        int    lo;
        int    thr;
        bit    dat;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    // bench reference state
    int m_up = 0, m_lo = 0;
    bit m_acq_prev = 1'b0;
    bit m_dat = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    peak_slicer dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_in(smp_in),
        .lvl_acq(lvl_acq), .freeze_n(freeze_n), .pk_up(pk_up), .pk_lo(pk_lo),
        .thresh(thresh), .mode(mode), .bit_out(bit_out)
    );

    task automatic check(input bit ok, input string tag, input string got, input string want);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %s expected %s", tag, got, want);
        end
    endtask

    function automatic int mid(input int a, input int b);
        return (a + b) >>> 1;
    endfunction

    // driver: one strobe, pushes the expected result
    task automatic strobe(input int s, input bit a, input bit h, input string tag);
        exp_t e;
        int   exp_mode;
        int   thr_old;
        @(negedge clk);
        smp_in = W'(s); lvl_acq = a; freeze_n = h;
        #1;
        exp_mode = a ? (m_acq_prev ? 1 : 0) : (h ? 2 : 3);
        check(mode == 2'(exp_mode), {tag, " mode"}, $sformatf("%0d", mode), $sformatf("%0d", exp_mode));
        thr_old = mid(m_up, m_lo);
        m_dat = (s > thr_old) ? 1'b0 : 1'b1;
        case (exp_mode)
            0: begin
                m_up = m_up + (((s >>> 1) - m_up) >>> 1);
                m_lo = m_lo + (((s >>> 1) - m_lo) >>> 1);
            end
            1: begin
                if (s > m_up) m_up = m_up + ((s - m_up) >>> 1);
                if (s < m_lo) m_lo = m_lo + ((s - m_lo) >>> 1);
            end
            2: begin
                if (s > thr_old) m_up = m_up + ((s - m_up) >>> 4);
                if (s < thr_old) m_lo = m_lo + ((s - m_lo) >>> 4);
            end
            default: begin
                m_up = m_up - (m_up >>> 11);
                m_lo = m_lo - (m_lo >>> 11);
            end
        endcase
        m_acq_prev = a;
        e.up = m_up; e.lo = m_lo; e.thr = mid(m_up, m_lo); e.dat = m_dat; e.tag = tag;
        sb_q.push_back(e);
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    // monitor: pops and compares after each strobe edge
    initial begin
        forever begin
            @(posedge clk);
            if (smp_stb === 1'b1) begin
                exp_t e;
                #1;
                e = sb_q.pop_front();
                check(int'(pk_up) == e.up && int'(pk_lo) == e.lo && int'(thresh) == e.thr && bit_out == e.dat,
                      e.tag,
                      $sformatf("up=%0d lo=%0d thr=%0d bit=%0d", pk_up, pk_lo, thresh, bit_out),
                      $sformatf("up=%0d lo=%0d thr=%0d bit=%0d", e.up, e.lo, e.thr, e.dat));
            end
        end
    end

    task automatic idle_check(input int n);
        repeat (n) @(negedge clk);
        check(int'(pk_up) == m_up && int'(pk_lo) == m_lo && bit_out == m_dat, "R8 idle",
              $sformatf("up=%0d lo=%0d bit=%0d", pk_up, pk_lo, bit_out),
              $sformatf("up=%0d lo=%0d bit=%0d", m_up, m_lo, m_dat));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(pk_up == 0 && pk_lo == 0 && thresh == 0 && bit_out == 1'b0, "R8 reset",
              $sformatf("up=%0d lo=%0d thr=%0d bit=%0d", pk_up, pk_lo, thresh, bit_out), "all zero");

        // R1 clamp on acquire rise
        strobe(8000, 1, 1, "R1 clamp");
        // R2 fast capture, both sides
        strobe(12000, 1, 1, "R2 fast up");
        strobe(-12000, 1, 1, "R2 fast lo");
        strobe(14000, 1, 1, "R2 fast up2");
        strobe(100, 1, 1, "R2 fast inside");
        strobe(-15000, 1, 1, "R2 fast lo2");
        // R5 freeze_n low while acquiring: still fast
        strobe(16000, 1, 0, "R5 freeze ignored up");
        strobe(-16000, 1, 0, "R5 freeze ignored lo");
        idle_check(5);
        // R3 averaging
        strobe(9000, 0, 1, "R3 avg up");
        strobe(-9000, 0, 1, "R3 avg lo");
        strobe(11000, 0, 1, "R3 avg up2");
        strobe(-20, 0, 1, "R3 avg near thr");
        // R7 equal to threshold slices to 1
        strobe(mid(m_up, m_lo), 0, 1, "R7 equal thr");
        strobe(mid(m_up, m_lo) + 1, 0, 1, "R7 just above");
        // R4 hold leakage
        for (int i = 0; i < 6; i++) strobe(15000, 0, 0, "R4 hold leak");
        idle_check(4);
        // R1 reacquire after low
        strobe(-6000, 1, 0, "R1 reclamp");
        strobe(-7000, 1, 1, "R2 after reclamp");
        strobe(3000, 0, 1, "R6 avg thr");
        idle_check(3);
        done = 1'b1;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule